// File: doc/BRIEF.md
# Asynchronous Serial Port

This block is a byte-wide asynchronous serial transceiver with a small register interface. A control register sets the bit-clock divide ratio, the character format, the transmit control (request-to-send level, transmit interrupt enable, break) and the receive interrupt enable. A status register reports buffer states, the two modem inputs, the receive errors and a combined interrupt request. Two data registers hold one transmit character and one received character. No FIFOs are present.

The divide field also carries a master reset code. After a hardware reset the control register holds that code, so software must write a working divide value before the port transmits or receives. The receiver oversamples the line at the input clock and takes each bit at its centre in the divided modes. The transmitter sends a start bit, the data bits LSB first, an optional parity bit and one or two stop bits.

Top module: `async_serial_port`

## Requirements
- R1: Control bits [1:0] set the bit period in input clocks: code 0 gives 1, code 1 gives 16 and code 2 gives 64. The transmitter holds each frame bit for exactly that many clocks, and the receiver uses the same period.
- R2: Control bits [4:2] select the frame. Code 0 is 7 data bits, even parity, 2 stop bits. Code 1 is 7, odd, 2. Code 2 is 7, even, 1. Code 3 is 7, odd, 1. Code 4 is 8 data bits, no parity, 2 stop bits. Code 5 is 8, none, 1. Code 6 is 8, even, 1. Code 7 is 8, odd, 1. Data is sent LSB first after a low start bit, and a received 7-bit character reads back with bit 7 = 0.
- R3: Control bits [6:5] set transmit control. Code 1 enables the transmit interrupt. Code 2 drives `rts_o` high. Codes 0, 1 and 3 drive `rts_o` low.
- R4: Transmit control code 3 holds `txd_o` low continuously (break) while the divide field is not 3.
- R5: Control bit 7 enables the receive interrupt.
- R6: The status byte (reg_sel = 0) has these bits: [0] receive full, [1] transmit empty, [2] `dcd_i`, [3] `cts_i`, [4] framing error, [5] overrun, [6] parity error, [7] interrupt request.
- R7: In divide-16 and divide-64 modes the receiver samples each bit at its centre. A low first stop bit sets the framing error flag.
- R8: A received parity bit that does not match the selected even or odd parity sets the parity error flag. Formats without parity never set it.
- R9: When a character completes while receive full is still set, overrun is set and the new character is dropped. The data register keeps the older character.
- R10: `irq_o` is high exactly when (receive interrupt enabled and receive full), or (transmit interrupt enabled and transmit empty), or (receive interrupt enabled and overrun).
- R11: While the divide field is 3 (master reset), the full, empty, framing, overrun and parity flags read 0, `txd_o` stays high and writes to the data register are dropped. When a working divide code is written, transmit empty reads 1.
- R12: A read of the data register (reg_sel = 1) clears receive full, framing error, parity error and overrun. A write of the data register clears transmit empty until the transmitter takes the character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on data read) |
| reg_sel | input | 1 | 0 = control (write) / status (read), 1 = data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: status or received character |
| rxd_i | input | 1 | Serial receive line, synchronous to clk |
| dcd_i | input | 1 | Carrier detect input |
| cts_i | input | 1 | Clear-to-send input |
| txd_o | output | 1 | Serial transmit line |
| rts_o | output | 1 | Request-to-send level |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that break and master reset override the line, that no interrupt is raised with both enables off, and that a data read clears receive full. They also check that a data write clears transmit empty and that the held character does not change when overrun rises. Only the bench scenarios can show frame contents, bit timing at each divide ratio, centre sampling, parity and framing detection across all eight formats, and that a write made during master reset is never transmitted.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
// Shared types for the asynchronous serial port: frame description,
// divide-field codes and receiver states. Assumes nothing beyond IEEE 1800.
package sp_pkg;

    typedef struct packed {
        logic eight;     // 8 data bits when set, else 7
        logic par_en;    // parity bit present
        logic par_odd;   // odd parity when set
        logic two_stop;  // two stop bits when set
    } fmt_t;

    typedef enum logic [1:0] {
        DIV_1  = 2'd0,
        DIV_16 = 2'd1,
        DIV_64 = 2'd2,
        DIV_MR = 2'd3
    } div_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    // Map the three-bit format code onto the frame description.
    function automatic fmt_t decode_fmt(input logic [2:0] code);
        fmt_t f;
        case (code)
            3'd0:    f = '{eight:1'b0, par_en:1'b1, par_odd:1'b0, two_stop:1'b1};
            3'd1:    f = '{eight:1'b0, par_en:1'b1, par_odd:1'b1, two_stop:1'b1};
            3'd2:    f = '{eight:1'b0, par_en:1'b1, par_odd:1'b0, two_stop:1'b0};
            3'd3:    f = '{eight:1'b0, par_en:1'b1, par_odd:1'b1, two_stop:1'b0};
            3'd4:    f = '{eight:1'b1, par_en:1'b0, par_odd:1'b0, two_stop:1'b1};
            3'd5:    f = '{eight:1'b1, par_en:1'b0, par_odd:1'b0, two_stop:1'b0};
            3'd6:    f = '{eight:1'b1, par_en:1'b1, par_odd:1'b0, two_stop:1'b0};
            default: f = '{eight:1'b1, par_en:1'b1, par_odd:1'b1, two_stop:1'b0};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/sp_tx.sv
`timescale 1ns/1ps
// Transmit shifter. Builds a complete frame from one character and shifts
// it out LSB first, holding each bit for reload+1 clocks.
// Assumes: start is only honoured while idle; clr returns the line to idle.
module sp_tx #(
    parameter int CNT_W   = 6,
    parameter int FRAME_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             start,
    input  logic [7:0]       data,
    input  sp_pkg::fmt_t     fmt,
    input  logic [CNT_W-1:0] reload,
    output logic             busy,
    output logic             line
);
    localparam int LEFT_W = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame, sh;
    logic [LEFT_W-1:0]  nbits, left;
    logic [CNT_W-1:0]   cnt;
    logic               par;

    // Assemble start, data, parity and stop bits; unused upper bits idle high.
    always_comb begin
        par   = ^(data & (fmt.eight ? 8'hFF : 8'h7F)) ^ fmt.par_odd;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (i < 7 || fmt.eight) frame[i+1] = data[i];
        end
        if (fmt.par_en) frame[fmt.eight ? 9 : 8] = par;
        nbits = LEFT_W'(1 + (fmt.eight ? 8 : 7) + (fmt.par_en ? 1 : 0) + (fmt.two_stop ? 2 : 1));
    end

    // Load a frame when idle, then shift one bit per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                sh   <= frame;
                left <= nbits;
                cnt  <= reload;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            cnt  <= reload;
            left <= left - 1'b1;
            if (left == LEFT_W'(1)) busy <= 1'b0;
        end
    end

    assign line = sh[0];

endmodule

// File: rtl/sp_rx.sv
`timescale 1ns/1ps
// Receive sequencer. Detects a start bit, waits half a period to confirm
// it (divided modes) and then samples each bit at its centre.
// Assumes: rxd is already synchronous to clk; done is a one-cycle pulse
// with data, pe and fe valid alongside it.
module sp_rx #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rxd,
    input  logic             eight,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             div1,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] half,
    output logic             done,
    output logic [7:0]       data,
    output logic             pe,
    output logic             fe
);
    import sp_pkg::*;

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [2:0]       dcount;
    logic [7:0]       sh;
    logic             par_bit;
    logic [2:0]       last;

    assign last = eight ? 3'd7 : 3'd6;

    // Walk start, data, parity and stop bits, sampling when cnt reaches 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            dcount  <= '0;
            sh      <= '0;
            par_bit <= 1'b0;
            done    <= 1'b0;
            data    <= '0;
            pe      <= 1'b0;
            fe      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                RX_IDLE: if (!rxd) begin
                    sh     <= '0;
                    dcount <= '0;
                    if (div1) begin
                        state <= RX_DATA;
                        cnt   <= '0;
                    end else begin
                        state <= RX_START;
                        cnt   <= half;
                    end
                end
                RX_START: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (!rxd) begin
                    state <= RX_DATA;
                    cnt   <= reload;
                end else begin
                    state <= RX_IDLE;
                end
                RX_DATA: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    sh[dcount] <= rxd;
                    cnt        <= reload;
                    dcount     <= dcount + 1'b1;
                    if (dcount == last) state <= par_en ? RX_PAR : RX_STOP;
                end
                RX_PAR: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    par_bit <= rxd;
                    cnt     <= reload;
                    state   <= RX_STOP;
                end
                RX_STOP: if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    done  <= 1'b1;
                    data  <= sh;
                    fe    <= !rxd;
                    pe    <= par_en && (par_bit != (^sh ^ par_odd));
                    state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/async_serial_port.sv
`timescale 1ns/1ps
// Asynchronous serial port top: control/status/data registers, bit-period
// selection, interrupt combination and line muxing for break and reset.
// Assumes: one register access per cycle; rxd_i, dcd_i, cts_i synchronous.
module async_serial_port #(
    parameter int MID_DIV  = 16,
    parameter int SLOW_DIV = 64,
    parameter int FRAME_W  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       reg_sel,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       rxd_i,
    input  logic       dcd_i,
    input  logic       cts_i,
    output logic       txd_o,
    output logic       rts_o,
    output logic       irq_o
);
    import sp_pkg::*;

    localparam int CNT_W = $clog2(SLOW_DIV);

    logic [7:0]       ctrl_q, tdr_q, rdr_q;
    logic             tdre_q, full_q, fe_q, pe_q, ovr_q;
    div_e             div;
    fmt_t             fmt;
    logic             mr, rie, tie, brk, div1;
    logic [CNT_W-1:0] reload, half;
    logic             tx_busy, tx_line, tx_start;
    logic             rx_done, rx_pe, rx_fe;
    logic [7:0]       rx_data;
    logic             rd_clr, wr_data, tdre_vis;
    logic [7:0]       status;

    assign div  = div_e'(ctrl_q[1:0]);
    assign fmt  = decode_fmt(ctrl_q[4:2]);
    assign mr   = (div == DIV_MR);
    assign div1 = (div == DIV_1);
    assign tie  = (ctrl_q[6:5] == 2'd1);
    assign brk  = (ctrl_q[6:5] == 2'd3);
    assign rie  = ctrl_q[7];

    // Bit period reload values and half-period start confirmation delay.
    always_comb begin
        case (div)
            DIV_16: begin
                reload = CNT_W'(MID_DIV - 1);
                half   = CNT_W'(MID_DIV / 2 - 1);
            end
            DIV_64: begin
                reload = CNT_W'(SLOW_DIV - 1);
                half   = CNT_W'(SLOW_DIV / 2 - 1);
            end
            default: begin
                reload = '0;
                half   = '0;
            end
        endcase
    end

    assign rd_clr   = rd_en & reg_sel;
    assign wr_data  = wr_en & reg_sel & ~mr;
    assign tx_start = ~tdre_q & ~tx_busy & ~mr;

    sp_tx #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .clr(mr), .start(tx_start), .data(tdr_q),
        .fmt(fmt), .reload(reload), .busy(tx_busy), .line(tx_line)
    );

    sp_rx #(.CNT_W(CNT_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .clr(mr), .rxd(rxd_i), .eight(fmt.eight),
        .par_en(fmt.par_en), .par_odd(fmt.par_odd), .div1(div1),
        .reload(reload), .half(half), .done(rx_done), .data(rx_data),
        .pe(rx_pe), .fe(rx_fe)
    );

    // Control register; hardware reset leaves the port in master reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctrl_q <= 8'h03;
        else if (wr_en && !reg_sel) ctrl_q <= wdata;
    end

    // Buffer flags, holding registers and error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdr_q  <= '0;
            rdr_q  <= '0;
            tdre_q <= 1'b1;
            full_q <= 1'b0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
            ovr_q  <= 1'b0;
        end else if (mr) begin
            tdre_q <= 1'b1;
            full_q <= 1'b0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (rd_clr) begin
                full_q <= 1'b0;
                fe_q   <= 1'b0;
                pe_q   <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (tx_start) tdre_q <= 1'b1;
            if (wr_data) begin
                tdr_q  <= wdata;
                tdre_q <= 1'b0;
            end
            if (rx_done) begin
                if (full_q && !rd_clr) begin
                    ovr_q <= 1'b1;
                end else begin
                    rdr_q  <= fmt.eight ? rx_data : {1'b0, rx_data[6:0]};
                    full_q <= 1'b1;
                    fe_q   <= rx_fe;
                    pe_q   <= rx_pe;
                end
            end
        end
    end

    assign tdre_vis = tdre_q & ~mr;
    assign irq_o    = (rie & full_q) | (tie & tdre_vis) | (rie & ovr_q);
    assign status   = {irq_o, pe_q, ovr_q, fe_q, cts_i, dcd_i, tdre_vis, full_q};
    assign rdata    = reg_sel ? rdr_q : status;
    assign rts_o    = (ctrl_q[6:5] == 2'd2);
    assign txd_o    = mr ? 1'b1 : (brk ? 1'b0 : tx_line);

endmodule

// File: rtl/sp_port_chk.sv
`timescale 1ns/1ps
// Property checker for the serial port, attached by bind. It observes
// ports and internal state only and drives nothing.
module sp_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       reg_sel,
    input logic       txd_o,
    input logic       irq_o,
    input logic [7:0] ctrl_q,
    input logic       tdre_q,
    input logic       full_q,
    input logic       ovr_q,
    input logic [7:0] rdr_q,
    input logic       rx_done
);
    p_break_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[6:5] == 2'd3 && ctrl_q[1:0] != 2'd3) |-> !txd_o);

    p_mr_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'd3) |-> (txd_o && !irq_o));

    p_irq_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[7] && ctrl_q[6:5] != 2'd1) |-> !irq_o);

    p_wr_clears_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel && ctrl_q[1:0] != 2'd3) |=> !tdre_q);

    p_rd_clears_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel && !rx_done) |=> !full_q);

    p_ovr_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $stable(rdr_q));

endmodule

bind async_serial_port sp_port_chk i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .txd_o(txd_o), .irq_o(irq_o), .ctrl_q(ctrl_q), .tdre_q(tdre_q),
    .full_q(full_q), .ovr_q(ovr_q), .rdr_q(rdr_q), .rx_done(rx_done)
);

// File: tb/test_async_serial_port.sv
`timescale 1ns/1ps
module test_async_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, reg_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rxd = 1'b1, dcd = 1'b0, cts = 1'b0;
    logic       txd, rts, irq;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    async_serial_port i_async_serial_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .rxd_i(rxd), .dcd_i(dcd), .cts_i(cts),
        .txd_o(txd), .rts_o(rts), .irq_o(irq)
    );

    // {ctrl[7:0], data[7:0], bad parity, bad stop}
    localparam logic [17:0] VECS [9] = '{
        {8'h14, 8'hA5, 1'b0, 1'b0},
        {8'h01, 8'h3C, 1'b0, 1'b0},
        {8'h05, 8'h55, 1'b1, 1'b0},
        {8'h0A, 8'h7F, 1'b0, 1'b0},
        {8'h0D, 8'h12, 1'b0, 1'b1},
        {8'h11, 8'hF0, 1'b0, 1'b0},
        {8'h18, 8'h81, 1'b1, 1'b0},
        {8'h1D, 8'hC3, 1'b0, 1'b0},
        {8'h1E, 8'h00, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        @(negedge clk);
        reg_sel = sel; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic int ratio(input logic [1:0] dc);
        return (dc == 2'd0) ? 1 : (dc == 2'd1) ? 16 : 64;
    endfunction

    function automatic logic [11:0] mkframe(input logic [7:0] d, input logic [2:0] f,
                                            input bit bp, input bit bs, output int n);
        logic [11:0] fr;
        int k;
        bit eight, pen, two;
        eight = f[2];
        pen   = !(f == 3'd4 || f == 3'd5);
        two   = (f == 3'd0 || f == 3'd1 || f == 3'd4);
        fr = '1; fr[0] = 1'b0; k = 1;
        for (int i = 0; i < (eight ? 8 : 7); i++) begin fr[k] = d[i]; k++; end
        if (pen) begin
            fr[k] = ^(eight ? d : {1'b0, d[6:0]}) ^ f[0] ^ bp;
            k++;
        end
        fr[k] = ~bs; k++;
        if (two) begin fr[k] = 1'b1; k++; end
        n = k;
        return fr;
    endfunction

    task automatic send_rx(input int r, input logic [11:0] fr, input int n);
        for (int i = 0; i < n; i++) begin
            rxd = fr[i];
            repeat (r) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cap_tx(input int r, input int n, output logic [11:0] got, output bit ok);
        int t;
        t = 0;
        while (txd === 1'b1 && t < 5000) begin @(negedge clk); t++; end
        ok = (t < 5000);
        repeat (r / 2) @(negedge clk);
        got = '1;
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            repeat (r) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  v, ctrl, d, exp_d;
        logic [11:0] fr, got, mask;
        int          n, r;
        bit          ok, quiet;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 R6: after reset the port sits in master reset, all flags low
        rd(1'b0, v);
        chk(v == 8'h00, "R11 reset status", v, 8'h00);
        chk(txd == 1'b1 && irq == 1'b0 && rts == 1'b0, "R11 reset lines", {txd, irq, rts}, 3'b100);

        // R6: modem inputs appear at bits 2 and 3
        dcd = 1'b1; cts = 1'b0;
        rd(1'b0, v);
        chk(v[3:2] == 2'b01, "R6 dcd bit", v[3:2], 2'b01);
        dcd = 1'b0; cts = 1'b1;
        rd(1'b0, v);
        chk(v[3:2] == 2'b10, "R6 cts bit", v[3:2], 2'b10);
        cts = 1'b0;

        // R1 R2 R7 R8 R12: walk the format/divide vector table
        for (int vi = 0; vi < 9; vi++) begin
            ctrl = VECS[vi][17:10];
            d    = VECS[vi][9:2];
            r    = ratio(ctrl[1:0]);
            wr(1'b0, ctrl);
            fr = mkframe(d, ctrl[4:2], VECS[vi][1], VECS[vi][0], n);
            send_rx(r, fr, n);
            rd(1'b0, v);
            chk(v[0] == 1'b1, "R7 receive full", v[0], 1'b1);
            chk(v[4] == VECS[vi][0], "R7 framing flag", v[4], VECS[vi][0]);
            chk(v[6] == (VECS[vi][1] & (ctrl[4:2] != 3'd4) & (ctrl[4:2] != 3'd5)),
                "R8 parity flag", v[6], VECS[vi][1]);
            exp_d = ctrl[4] ? d : {1'b0, d[6:0]};
            rd(1'b1, v);
            chk(v == exp_d, "R2 received data", v, exp_d);
            rd(1'b0, v);
            chk(v[0] == 1'b0 && v[4] == 1'b0 && v[6] == 1'b0, "R12 read clears", v, 8'h02);
            wr(1'b1, d);
            fr = mkframe(d, ctrl[4:2], 1'b0, 1'b0, n);
            cap_tx(r, n, got, ok);
            mask = 12'((1 << n) - 1);
            chk(ok && ((got ^ fr) & mask) == 12'h0, "R1 transmitted frame", got & mask, fr & mask);
            repeat (r + 4) @(negedge clk);
        end

        // R9: second character while full sets overrun and is discarded
        wr(1'b0, 8'h15);
        fr = mkframe(8'h11, 3'd5, 1'b0, 1'b0, n);
        send_rx(16, fr, n);
        fr = mkframe(8'h22, 3'd5, 1'b0, 1'b0, n);
        send_rx(16, fr, n);
        rd(1'b0, v);
        chk(v[5] == 1'b1 && v[0] == 1'b1, "R9 overrun flag", v, 8'h23);
        rd(1'b1, v);
        chk(v == 8'h11, "R9 older data kept", v, 8'h11);
        rd(1'b0, v);
        chk(v[5] == 1'b0, "R12 read clears overrun", v[5], 1'b0);

        // R5 R10: receive interrupt
        wr(1'b0, 8'h95);
        chk(irq == 1'b0, "R10 no irq when empty", irq, 1'b0);
        fr = mkframe(8'h6E, 3'd5, 1'b0, 1'b0, n);
        send_rx(16, fr, n);
        chk(irq == 1'b1, "R5 receive irq", irq, 1'b1);
        rd(1'b0, v);
        chk(v[7] == 1'b1, "R6 irq status bit", v[7], 1'b1);
        rd(1'b1, v);
        #1 chk(irq == 1'b0, "R10 irq drops after read", irq, 1'b0);

        // R3 R10: transmit interrupt and RTS level
        wr(1'b0, 8'h35);
        chk(irq == 1'b1 && rts == 1'b0, "R3 transmit irq", {irq, rts}, 2'b10);
        wr(1'b0, 8'h55);
        chk(irq == 1'b0 && rts == 1'b1, "R3 rts high", {irq, rts}, 2'b01);

        // R4: break holds the line low
        wr(1'b0, 8'h75);
        chk(txd == 1'b0, "R4 break low", txd, 1'b0);
        repeat (40) @(negedge clk);
        chk(txd == 1'b0 && rts == 1'b0, "R4 break held", {txd, rts}, 2'b00);

        // R12: data write clears transmit empty until taken
        wr(1'b0, 8'h15);
        wr(1'b1, 8'hAA);
        wr(1'b1, 8'h5B);
        rd(1'b0, v);
        chk(v[1] == 1'b0, "R12 write clears empty", v[1], 1'b0);
        repeat (400) @(negedge clk);
        rd(1'b0, v);
        chk(v[1] == 1'b1, "R12 empty after transfer", v[1], 1'b1);

        // R11: master reset clears flags and drops data writes
        fr = mkframe(8'h3D, 3'd5, 1'b1, 1'b1, n);
        send_rx(16, fr, n);
        wr(1'b0, 8'h03);
        rd(1'b0, v);
        chk(v == 8'h00 && txd == 1'b1, "R11 flags cleared", v, 8'h00);
        wr(1'b1, 8'h5A);
        repeat (50) @(negedge clk);
        chk(txd == 1'b1, "R11 line idle", txd, 1'b1);
        wr(1'b0, 8'h15);
        rd(1'b0, v);
        chk(v == 8'h02, "R11 empty after release", v, 8'h02);
        quiet = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) quiet = 1'b0;
        end
        chk(quiet, "R11 write dropped", quiet, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule